// File: doc/BRIEF.md
# Phase-Locked Triangle-Carrier PWM Channel Pair

This block produces two PWM outputs from one symmetric triangle carrier. A counter climbs from zero to a programmable period value and then falls back to zero. Each output is driven by a compare value that is applied on both the rising and the falling slope. Compare values pass through a shadow stage and become active only when the counter sits at zero, so a new duty never tears a carrier cycle in half.

Several instances can share one carrier timing. One instance reports each carrier zero on its sync output. The next instance takes that pulse on its sync input and reloads its counter with a programmed phase count. A three-phase bridge uses three instances in a chain with phase counts about one third and two thirds of a carrier apart. The phase value is a count, not an angle: one carrier lasts 2 × period clocks, so a 120° shift is (2 × period) / 3 counts. The reload adds two cycles of lag through the sync pipeline, so the effective lead of a follower is the phase count minus 2. A sticky zero-event interrupt flag with an acknowledge input is also provided.

Top module: `pwm_phase_gen`

## Requirements
- R1: With a fixed, nonzero `period` P, the counter runs 0, 1, …, P, P−1, …, 1, 0, 1, … so that one carrier lasts exactly 2·P clocks. With `sync_sel`=0, `sync_out` is high for exactly one clock per carrier, so a window of 4·P clocks holds 2 pulses.
- R2: Output `pwm_a` goes high the cycle after the counter equals the active compare A on the rising slope, and low the cycle after it equals it on the falling slope. It is high for 2·(P−A) clocks per carrier.
- R3: Output `pwm_b` (with `alt_b_mode`=0) goes low the cycle after the counter equals the active compare B on the rising slope, and high after the match on the falling slope. It is high for 2·B clocks per carrier.
- R4: A compare value of 0 or of P causes no change on its output. After reset such an output stays low.
- R5: With `alt_b_mode`=1, `pwm_b` ignores compare B. It goes low after the counter reads zero and high after the counter reads P, so it is high for P clocks per carrier.
- R6: A value on `cmp_a_wr`/`cmp_b_wr` is captured into a shadow register and copied to the active compare only when the counter equals zero. A change made just after a zero leaves the current carrier's pulse unchanged, and the new value applies from the next carrier.
- R7: When `phase_en`=1 and `sync_in`=1, the counter holds `phase_val` in the next cycle and keeps its counting direction. A follower fed from a leader's `sync_out` (zero mode), both released from reset together, leads the leader by `phase_val`−2 clocks.
- R8: When `phase_en`=0, `sync_in` has no effect on the counter.
- R9: With `sync_sel`=0, `sync_out` is high in the cycle after the counter reads zero. With `sync_sel`=1, `sync_out` equals `sync_in` delayed by one clock.
- R10: `zero_irq` is set the cycle after every counter-zero and stays set until `irq_ack` is high on a clock edge. If an acknowledge coincides with a counter-zero, the flag stays set.
- R11: While `rst_n` is low (synchronous), the counter is held at zero counting up and `pwm_a`, `pwm_b`, `sync_out` and `zero_irq` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period | input | CNT_W | Carrier turning point P |
| cmp_a_wr | input | CNT_W | Compare A, goes to shadow |
| cmp_b_wr | input | CNT_W | Compare B, goes to shadow |
| phase_val | input | CNT_W | Count loaded on a qualified sync |
| phase_en | input | 1 | Allows sync-in to reload the counter |
| sync_sel | input | 1 | 0: sync-out on zero, 1: pass sync-in through |
| alt_b_mode | input | 1 | 1: B cleared at zero, set at period |
| sync_in | input | 1 | Sync pulse from a leader instance |
| irq_ack | input | 1 | Clears the zero-event flag |
| pwm_a | output | 1 | Raw output A |
| pwm_b | output | 1 | Raw output B |
| sync_out | output | 1 | Sync pulse to a follower instance |
| zero_irq | output | 1 | Sticky counter-zero flag |

## Verification
Two events can fall in the same clock: an interrupt acknowledge and a fresh counter-zero event. The bench locates a zero from the `sync_out` pulse. It then raises `irq_ack` once on a mid-carrier cycle, where the flag must clear. It raises it again exactly 2·P−1 cycles after the marker, so the acknowledge meets the next zero, and the flag must read set afterwards. A second pair of events that can coincide is a phase reload and a compare match. This pair is judged through the lead measured between the rising edges of the leader's and the follower's A outputs.

// File: rtl/pwm_phase_pkg.sv
// Shared types for the phase-locked PWM channel pair.
// Assumes nothing beyond a single clock domain.
package pwm_phase_pkg;

    // Direction of the triangle counter.
    typedef enum logic {
        CNT_DOWN = 1'b0,
        CNT_UP   = 1'b1
    } cnt_dir_e;

    // Source of the sync output.
    typedef enum logic {
        SYNC_ON_ZERO = 1'b0,
        SYNC_PASS    = 1'b1
    } sync_src_e;

    // Number of compare channels in the pair.
    localparam int N_CMP = 2;
    localparam int CH_A  = 0;
    localparam int CH_B  = 1;

endpackage

// File: rtl/pwm_updown_carrier.sv
// Symmetric up-down carrier counter with phase reload.
// Counts 0..period..0. A phase load replaces the count but keeps the
// direction; the turn checks use >= and ==0 so the counter never leaves
// the range even after a load beyond the period. Period 0 parks at zero.
module pwm_updown_carrier
    import pwm_phase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] phase_val,
    input  logic             load_phase,
    output logic [CNT_W-1:0] cnt,
    output cnt_dir_e         dir
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_nxt;
    cnt_dir_e         dir_nxt;

    // Next count and direction for a free-running step.
    always_comb begin
        cnt_nxt = cnt;
        dir_nxt = dir;
        if (period == '0) begin
            cnt_nxt = '0;
            dir_nxt = CNT_UP;
        end else if (dir == CNT_UP) begin
            if (cnt >= period) begin
                cnt_nxt = cnt - ONE;
                dir_nxt = CNT_DOWN;
            end else begin
                cnt_nxt = cnt + ONE;
            end
        end else begin
            if (cnt == '0) begin
                cnt_nxt = ONE;
                dir_nxt = CNT_UP;
            end else begin
                cnt_nxt = cnt - ONE;
            end
        end
    end

    // Counter register: reset, phase reload, or one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            dir <= CNT_UP;
        end else if (load_phase) begin
            cnt <= phase_val;
        end else begin
            cnt <= cnt_nxt;
            dir <= dir_nxt;
        end
    end

endmodule

// File: rtl/pwm_cmp_shadow.sv
// Shadowed compare registers, one per channel.
// The shadow samples its write port every clock; the active copy takes
// the shadow only while the carrier reads zero.
module pwm_cmp_shadow #(
    parameter int CNT_W = 16,
    parameter int N_CH  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CH-1:0][CNT_W-1:0] cmp_wr,
    input  logic                       at_zero,
    output logic [N_CH-1:0][CNT_W-1:0] cmp_act
);

    logic [N_CH-1:0][CNT_W-1:0] cmp_shd;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        // Shadow stage: follows the write port.
        always_ff @(posedge clk) begin
            if (!rst_n) cmp_shd[ch] <= '0;
            else        cmp_shd[ch] <= cmp_wr[ch];
        end

        // Active stage: refreshed only at carrier zero.
        always_ff @(posedge clk) begin
            if (!rst_n)       cmp_act[ch] <= '0;
            else if (at_zero) cmp_act[ch] <= cmp_shd[ch];
        end
    end

endmodule

// File: rtl/pwm_action_qual.sv
// Output action qualifier for the two PWM outputs.
// Acts on the registered count and direction; outputs change one clock
// after the qualifying count. A compare of 0 or of the period is
// treated as no event.
module pwm_action_qual
    import pwm_phase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  cnt_dir_e         dir,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             alt_b,
    output logic             out_a,
    output logic             out_b
);

    logic hit_a;
    logic hit_b;
    logic at_zero;
    logic at_top;

    // Match decode with end-point suppression.
    always_comb begin
        hit_a   = (cnt == cmp_a) && (cmp_a != '0) && (cmp_a != period);
        hit_b   = (cnt == cmp_b) && (cmp_b != '0) && (cmp_b != period);
        at_zero = (cnt == '0);
        at_top  = (cnt == period) && (period != '0);
    end

    // Output A: set on the rising match, cleared on the falling match.
    always_ff @(posedge clk) begin
        if (!rst_n)     out_a <= 1'b0;
        else if (hit_a) out_a <= (dir == CNT_UP);
    end

    // Output B: compare mode or zero/period mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_b <= 1'b0;
        end else if (alt_b) begin
            if (at_zero)     out_b <= 1'b0;
            else if (at_top) out_b <= 1'b1;
        end else if (hit_b) begin
            out_b <= (dir == CNT_DOWN);
        end
    end

endmodule

// File: rtl/pwm_phase_gen.sv
// Phase-locked triangle-carrier PWM channel pair (top).
// Combines the carrier, shadowed compares and action qualifier, and adds
// the sync output and the sticky zero-event flag. All registers use a
// synchronous active-low reset.
module pwm_phase_gen
    import pwm_phase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp_a_wr,
    input  logic [CNT_W-1:0] cmp_b_wr,
    input  logic [CNT_W-1:0] phase_val,
    input  logic             phase_en,
    input  logic             sync_sel,
    input  logic             alt_b_mode,
    input  logic             sync_in,
    input  logic             irq_ack,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic             sync_out,
    output logic             zero_irq
);

    logic [CNT_W-1:0]            cnt_q;
    cnt_dir_e                    dir_q;
    logic                        load_phase;
    logic                        at_zero;
    logic [N_CMP-1:0][CNT_W-1:0] wr_cmp;
    logic [N_CMP-1:0][CNT_W-1:0] act_cmp;
    sync_src_e                   sync_src;

    // Qualified reload and zero decode.
    always_comb begin
        load_phase     = phase_en & sync_in;
        at_zero        = (cnt_q == '0);
        wr_cmp[CH_A]   = cmp_a_wr;
        wr_cmp[CH_B]   = cmp_b_wr;
        sync_src       = sync_src_e'(sync_sel);
    end

    pwm_updown_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk        (clk),
        .rst_n      (rst_n),
        .period     (period),
        .phase_val  (phase_val),
        .load_phase (load_phase),
        .cnt        (cnt_q),
        .dir        (dir_q)
    );

    pwm_cmp_shadow #(.CNT_W(CNT_W), .N_CH(N_CMP)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_wr  (wr_cmp),
        .at_zero (at_zero),
        .cmp_act (act_cmp)
    );

    pwm_action_qual #(.CNT_W(CNT_W)) u_action (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt    (cnt_q),
        .dir    (dir_q),
        .period (period),
        .cmp_a  (act_cmp[CH_A]),
        .cmp_b  (act_cmp[CH_B]),
        .alt_b  (alt_b_mode),
        .out_a  (pwm_a),
        .out_b  (pwm_b)
    );

    // Sync output: registered zero pulse or delayed pass-through.
    always_ff @(posedge clk) begin
        if (!rst_n)                    sync_out <= 1'b0;
        else if (sync_src == SYNC_PASS) sync_out <= sync_in;
        else                           sync_out <= at_zero;
    end

    // Sticky zero flag: a new zero wins over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       zero_irq <= 1'b0;
        else if (at_zero) zero_irq <= 1'b1;
        else if (irq_ack) zero_irq <= 1'b0;
    end

endmodule

// File: rtl/pwm_phase_gen_chk.sv
// Assertion checker for pwm_phase_gen, attached by bind.
// Observes the carrier count and direction and the active compares.
module pwm_phase_gen_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] period,
    input logic [CNT_W-1:0] phase_val,
    input logic             phase_en,
    input logic             sync_sel,
    input logic             sync_in,
    input logic [CNT_W-1:0] cnt,
    input logic             dir,
    input logic [CNT_W-1:0] act_a,
    input logic [CNT_W-1:0] act_b,
    input logic             pwm_a,
    input logic             sync_out,
    input logic             zero_irq
);

    // R1: without a reload the count moves by exactly one.
    a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!(phase_en && sync_in) && period != '0 && $stable(period))
        |=> (cnt == $past(cnt) + CNT_W'(1) || cnt == $past(cnt) - CNT_W'(1)));

    // R2: rising-slope match on A drives A high.
    a_r2_a_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (dir && cnt == act_a && act_a != '0 && act_a != period) |=> pwm_a);

    // R4: an end-point compare leaves A untouched.
    a_r4_a_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (act_a == '0 || act_a == period) |=> $stable(pwm_a));

    // R6: active compares change only after a zero count.
    a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> ($stable(act_a) && $stable(act_b)));

    // R7: a qualified sync loads the phase and keeps the direction.
    a_r7_phase_load: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en && sync_in) |=> (cnt == $past(phase_val) && dir == $past(dir)));

    // R9: pass-through mode delays sync-in by one clock.
    a_r9_sync_pass: assert property (@(posedge clk) disable iff (!rst_n)
        sync_sel |=> (sync_out == $past(sync_in)));

    // R10: every zero count sets the flag.
    a_r10_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |=> zero_irq);

endmodule

bind pwm_phase_gen pwm_phase_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .period    (period),
    .phase_val (phase_val),
    .phase_en  (phase_en),
    .sync_sel  (sync_sel),
    .sync_in   (sync_in),
    .cnt       (cnt_q),
    .dir       (dir_q),
    .act_a     (act_cmp[0]),
    .act_b     (act_cmp[1]),
    .pwm_a     (pwm_a),
    .sync_out  (sync_out),
    .zero_irq  (zero_irq)
);

// File: tb/pwm_phase_gen_bench.sv
module pwm_phase_gen_bench;

    localparam int W = 16;
    localparam int WATCHDOG = 150000;

    // period, cmpA, cmpB, alt, exp A high, exp B high, exp sync pulses in 4P
    localparam int NV = 6;
    localparam int VEC [NV][7] = '{
        '{20,  5, 15, 0, 30, 30, 2},
        '{20, 15,  4, 0, 10,  8, 2},
        '{16,  0,  8, 0,  0, 16, 2},
        '{16, 16,  0, 0,  0,  0, 2},
        '{24,  6, 10, 1, 36, 24, 2},
        '{ 8,  1,  7, 0, 14, 14, 2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] period = 16'd20, cmp_a = '0, cmp_b = '0;
    logic alt_b = 1'b0, irq_ack = 1'b0;
    logic [W-1:0] s_phase = '0;
    logic s_phase_en = 1'b0, s_sync_sel = 1'b0;
    logic m_a, m_b, m_sync, m_irq;
    logic s_a, s_b, s_sync, s_irq;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    pwm_phase_gen #(.CNT_W(W)) u_pwm_phase_gen (
        .clk(clk), .rst_n(rst_n), .period(period), .cmp_a_wr(cmp_a),
        .cmp_b_wr(cmp_b), .phase_val('0), .phase_en(1'b0), .sync_sel(1'b0),
        .alt_b_mode(alt_b), .sync_in(1'b0), .irq_ack(irq_ack),
        .pwm_a(m_a), .pwm_b(m_b), .sync_out(m_sync), .zero_irq(m_irq)
    );

    pwm_phase_gen #(.CNT_W(W)) u_follower (
        .clk(clk), .rst_n(rst_n), .period(period), .cmp_a_wr(cmp_a),
        .cmp_b_wr(cmp_b), .phase_val(s_phase), .phase_en(s_phase_en),
        .sync_sel(s_sync_sel), .alt_b_mode(alt_b), .sync_in(m_sync),
        .irq_ack(1'b0), .pwm_a(s_a), .pwm_b(s_b), .sync_out(s_sync),
        .zero_irq(s_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_sync();
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (m_sync) break;
        end
    endtask

    task automatic pulse_width(output int w);
        logic prev;
        w = 0;
        prev = m_a;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (!prev && m_a) break;
            prev = m_a;
        end
        w = 1;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (!m_a) break;
            w++;
        end
    endtask

    task automatic lead(output int d);
        int t;
        int last_s;
        logic pm, ps;
        d = -1;
        t = 0;
        last_s = -1;
        do_reset();
        repeat (200) @(negedge clk);
        pm = m_a;
        ps = s_a;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            t++;
            if (!ps && s_a) last_s = t;
            if (!pm && m_a && last_s >= 0) begin
                d = t - last_s;
                break;
            end
            pm = m_a;
            ps = s_a;
        end
    endtask

    initial begin : main
        int ha, hb, ns, p, w, d, mism, pulses;
        logic prev_sync;

        // R11: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(m_a == 1'b0, "R11 pwm_a in reset", m_a, 0);
        check(m_b == 1'b0, "R11 pwm_b in reset", m_b, 0);
        check(m_sync == 1'b0, "R11 sync_out in reset", m_sync, 0);
        check(m_irq == 1'b0, "R11 zero_irq in reset", m_irq, 0);

        // R1 R2 R3 R4 R5: table walk
        for (int i = 0; i < NV; i++) begin
            p      = VEC[i][0];
            period = W'(VEC[i][0]);
            cmp_a  = W'(VEC[i][1]);
            cmp_b  = W'(VEC[i][2]);
            alt_b  = VEC[i][3] != 0;
            do_reset();
            repeat (6 * p) @(negedge clk);
            ha = 0;
            hb = 0;
            for (int c = 0; c < 2 * p; c++) begin
                @(negedge clk);
                ha += int'(m_a);
                hb += int'(m_b);
            end
            ns = 0;
            for (int c = 0; c < 4 * p; c++) begin
                @(negedge clk);
                ns += int'(m_sync);
            end
            check(ha == VEC[i][4], "R2/R4 A high time", ha, VEC[i][4]);
            check(hb == VEC[i][5], (VEC[i][3] != 0) ? "R5 alt B high time" : "R3/R4 B high time",
                  hb, VEC[i][5]);
            check(ns == VEC[i][6], "R1 sync pulses per 4P", ns, VEC[i][6]);
        end

        // R6: shadowed compare applies from the next zero
        period = 16'd20;
        cmp_a  = 16'd15;
        cmp_b  = 16'd5;
        alt_b  = 1'b0;
        do_reset();
        repeat (100) @(negedge clk);
        wait_sync();
        cmp_a = 16'd5;
        pulse_width(w);
        check(w == 10, "R6 pulse after mid-carrier write keeps old compare", w, 10);
        pulse_width(w);
        check(w == 30, "R6 next carrier uses new compare", w, 30);

        // R7 R8: phase lead between leader and follower
        period     = 16'd30;
        cmp_a      = 16'd20;
        cmp_b      = 16'd10;
        s_phase    = 16'd10;
        s_phase_en = 1'b0;
        lead(d);
        check(d == 0, "R8 phase disabled ignores sync", d, 0);
        s_phase_en = 1'b1;
        lead(d);
        check(d == 8, "R7 lead with phase 10", d, 8);
        s_phase = 16'd25;
        lead(d);
        check(d == 23, "R7 lead with phase 25", d, 23);

        // R9: pass-through sync
        s_sync_sel = 1'b1;
        do_reset();
        repeat (5) @(negedge clk);
        mism = 0;
        pulses = 0;
        prev_sync = m_sync;
        for (int c = 0; c < 150; c++) begin
            @(negedge clk);
            if (s_sync != prev_sync) mism++;
            pulses += int'(prev_sync);
            prev_sync = m_sync;
        end
        check(mism == 0, "R9 pass-through mismatches", mism, 0);
        check(pulses >= 2, "R9 pulses seen in pass-through window", pulses, 2);
        s_sync_sel = 1'b0;

        // R10: acknowledge and coincident zero
        period = 16'd20;
        do_reset();
        repeat (50) @(negedge clk);
        wait_sync();
        check(m_irq == 1'b1, "R10 flag set after zero", m_irq, 1);
        irq_ack = 1'b1;
        @(negedge clk);
        check(m_irq == 1'b0, "R10 ack clears flag", m_irq, 0);
        irq_ack = 1'b0;
        repeat (2 * 20 - 2) @(negedge clk);
        check(m_irq == 1'b0, "R10 flag stays clear mid-carrier", m_irq, 0);
        irq_ack = 1'b1;
        @(negedge clk);
        check(m_irq == 1'b1, "R10 zero wins over coincident ack", m_irq, 1);
        irq_ack = 1'b0;
        @(negedge clk);
        check(m_irq == 1'b1, "R10 flag sticky", m_irq, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule